// File: doc/BRIEF.md
# Display Memory Address Generator with Cursor Match

This block forms the 14-bit display memory address for every character slot of a raster display. A running address register advances once per enabled character clock. Whenever a rasterline ends, it is reloaded from a row-start register. That register is written from the running address during the last rasterline of a character row, at the slot one past the visible width. The captured value is therefore the first character of the next row, and every rasterline of a row fetches the same stretch of memory. At the end of a frame, both the running address and the row-start register take the programmed start address.

Horizontal and vertical timing come from neighbouring counter blocks as single-cycle markers. These markers are valid in the character slot that they describe. The running address is compared with a cursor address, and a cursor flag is raised while the rasterline lies inside the cursor window. A mode input selects one of two counting schemes. The first is plain binary. The second is a row/column scheme: the low 8 bits form a column that wraps by itself, and the upper 6 bits form a row number that steps by one at each new character row.

Top module: `disp_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `mem_addr` becomes 0 and the row-start register is cleared to 0.
- R2: When `char_en` and `frame_load` are both high at an edge, `mem_addr` and the row-start register both take `start_addr`.
- R3: In binary mode (`rowcol_mode`=0), a plain enabled slot (no `frame_load`, no `line_end`) sets `mem_addr` to the old value plus 1, modulo 16384 (3FFF is followed by 0000).
- R4: When `char_en` and `line_end` are high and `frame_load` is low, `mem_addr` takes the row-start register value.
- R5: In binary mode, an enabled slot with both `row_last` and `hdisp_hit` high and `frame_load` low copies the current `mem_addr` into the row-start register. `hdisp_hit` has no effect without `row_last`, and neither does `row_last` without `hdisp_hit`.
- R6: `frame_load` takes priority over `line_end` and over a capture in the same slot.
- R7: While `char_en` is low, `mem_addr` and the row-start register hold their values, whatever the other inputs are.
- R8: `cursor_on` is high, in the same cycle and without a register, exactly when `cur_rows` is high and `mem_addr` equals `cursor_addr`.
- R9: In row/column mode (`rowcol_mode`=1), a plain enabled slot adds 1 to `mem_addr[7:0]` modulo 256 and leaves `mem_addr[13:8]` unchanged.
- R10: In row/column mode, a capture writes `{mem_addr[13:8]+1 (mod 64), row_start[7:0]}` into the row-start register. This resets the column to the row's start column and steps the row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_en | input | 1 | Character clock enable; the state advances only when high |
| frame_load | input | 1 | Last slot of the frame; the next address comes from `start_addr` |
| line_end | input | 1 | Last slot of a rasterline; the next address comes from the row-start register |
| row_last | input | 1 | Current rasterline is the last one of its character row |
| hdisp_hit | input | 1 | Current slot is the first character past the visible width |
| cur_rows | input | 1 | Current rasterline is inside the cursor window |
| rowcol_mode | input | 1 | 0 selects binary counting, 1 selects row/column counting |
| start_addr | input | 14 | Frame start address |
| cursor_addr | input | 14 | Cursor address |
| mem_addr | output | 14 | Display memory address of the current slot |
| cursor_on | output | 1 | Cursor is active on the current slot |

## Verification
`mem_addr` and the row-start register change only at a rising edge where `char_en` is sampled high, so every stimulus shows up one edge later. `cursor_on` is combinational and is due in the same cycle as the `mem_addr` and cursor inputs that it compares. The bench drives every input at the falling edge and compares `mem_addr` at the next falling edge, after exactly one rising edge, against a reference model that it steps from the requirements. It compares `cursor_on` at that same falling edge against the inputs still applied. The row-start register is observed only through the `mem_addr` value that follows a later `line_end`.

// File: rtl/disp_addr_pkg.sv
// Shared definitions for the display address generator.
// Assumes: the address splits into a low column field and a high row field.
package disp_addr_pkg;
    typedef enum logic {
        AM_BINARY = 1'b0,
        AM_ROWCOL = 1'b1
    } addr_mode_e;
endpackage

// File: rtl/dag_addr_counter.sv
// Running display address register.
// Loads the start address at frame end, loads the row-start value at line
// end, and otherwise steps either in binary or within the column field.
// Assumes: frame_load outranks line_end; all updates are gated by char_en.
module dag_addr_counter
    import disp_addr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_en,
    input  logic              frame_load,
    input  logic              line_end,
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] row_start,
    output logic [ADDR_W-1:0] addr
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic [ADDR_W-1:0] step_val;
    logic [COL_W-1:0]  col_inc;

    // Next address for a plain slot, chosen by the counting mode.
    always_comb begin
        col_inc = addr[COL_W-1:0] + 1'b1;
        if (mode == AM_ROWCOL)
            step_val = {addr[ADDR_W-1:COL_W], col_inc};
        else
            step_val = addr + 1'b1;
    end

    // Address register with frame load, line load and step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (char_en) begin
            if (frame_load)
                addr <= start_addr;
            else if (line_end)
                addr <= row_start;
            else
                addr <= step_val;
        end
    end

    AST_RESET_ADDR: assert property (@(posedge clk)
        !rst_n |=> addr == '0);                                          // R1
    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && frame_load) |=> addr == $past(start_addr));         // R2
    AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !frame_load && !line_end && mode == AM_BINARY)
        |=> addr == $past(addr) + 1'b1);                                 // R3
    AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && line_end && !frame_load) |=> addr == $past(row_start)); // R4
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !char_en |=> $stable(addr));                                     // R7
    AST_RC_ROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !frame_load && !line_end && mode == AM_ROWCOL)
        |=> addr[ADDR_W-1:COL_W] == $past(addr[ADDR_W-1:COL_W]));       // R9

    // The row field width must be positive.
    initial begin
        if (ROW_W < 1) $error("dag_addr_counter: COL_W must be below ADDR_W");
    end
endmodule

// File: rtl/dag_row_latch.sv
// Row-start register.
// Takes the start address at frame end. On the last rasterline of a row, at
// the first slot past the visible width, it captures the next row's start:
// the running address in binary mode, or the next row with the same start
// column in row/column mode.
// Assumes: frame_load outranks capture; all updates are gated by char_en.
module dag_row_latch
    import disp_addr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_en,
    input  logic              frame_load,
    input  logic              row_last,
    input  logic              hdisp_hit,
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_start
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic              capture;
    logic [ROW_W-1:0]  next_row;
    logic [ADDR_W-1:0] capture_val;

    // Value to capture for the next character row.
    always_comb begin
        capture  = row_last && hdisp_hit;
        next_row = addr[ADDR_W-1:COL_W] + 1'b1;
        if (mode == AM_ROWCOL)
            capture_val = {next_row, row_start[COL_W-1:0]};
        else
            capture_val = addr;
    end

    // Row-start register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_start <= '0;
        else if (char_en) begin
            if (frame_load)
                row_start <= start_addr;
            else if (capture)
                row_start <= capture_val;
        end
    end

    AST_LATCH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && frame_load) |=> row_start == $past(start_addr));    // R6
    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !char_en |=> $stable(row_start));                                // R7
    AST_NO_STRAY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !frame_load && !(row_last && hdisp_hit))
        |=> $stable(row_start));                                         // R5
    AST_RC_COL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !frame_load && mode == AM_ROWCOL)
        |=> row_start[COL_W-1:0] == $past(row_start[COL_W-1:0]));       // R10
endmodule

// File: rtl/dag_cursor_match.sv
// Cursor comparator: flags the slot whose address equals the cursor address
// while the rasterline lies inside the cursor window.
// Assumes: purely combinational; the output follows the address in the same cycle.
module dag_cursor_match #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cursor_addr,
    input  logic              cur_rows,
    output logic              cursor_on
);
    // Equality compare qualified by the cursor window.
    always_comb begin
        cursor_on = cur_rows && (addr == cursor_addr);
    end

    AST_CURSOR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_on |-> cur_rows);                                         // R8
    AST_CURSOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != cursor_addr) |-> !cursor_on);                           // R8
endmodule

// File: rtl/disp_addr_gen.sv
// Top of the display address generator: running address, row-start
// register and cursor comparator.
// Assumes: the timing markers are one-slot pulses from the horizontal and
// vertical counters and are valid in the slot they describe.
module disp_addr_gen
    import disp_addr_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int COL_W     = 8,
    parameter bit ROWCOL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_en,
    input  logic              frame_load,
    input  logic              line_end,
    input  logic              row_last,
    input  logic              hdisp_hit,
    input  logic              cur_rows,
    input  logic              rowcol_mode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] cursor_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cursor_on
);
    addr_mode_e        mode;
    logic [ADDR_W-1:0] row_start;

    // Mode selection; row/column counting can be left out by parameter.
    generate
        if (ROWCOL_EN) begin : g_mode_sel
            assign mode = rowcol_mode ? AM_ROWCOL : AM_BINARY;
        end else begin : g_mode_bin
            assign mode = AM_BINARY;
        end
    endgenerate

    dag_addr_counter #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_en    (char_en),
        .frame_load (frame_load),
        .line_end   (line_end),
        .mode       (mode),
        .start_addr (start_addr),
        .row_start  (row_start),
        .addr       (mem_addr)
    );

    dag_row_latch #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_en    (char_en),
        .frame_load (frame_load),
        .row_last   (row_last),
        .hdisp_hit  (hdisp_hit),
        .mode       (mode),
        .start_addr (start_addr),
        .addr       (mem_addr),
        .row_start  (row_start)
    );

    dag_cursor_match #(.ADDR_W(ADDR_W)) u_cur (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (mem_addr),
        .cursor_addr (cursor_addr),
        .cur_rows    (cur_rows),
        .cursor_on   (cursor_on)
    );
endmodule

// File: tb/sim_disp_addr_gen.sv
// Bench for disp_addr_gen: directed corner cases plus seeded random
// stimulus, checked against a reference model built from the requirements.
module sim_disp_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_en = 1'b0, frame_load = 1'b0, line_end = 1'b0;
    logic        row_last = 1'b0, hdisp_hit = 1'b0, cur_rows = 1'b0;
    logic        rowcol_mode = 1'b0;
    logic [13:0] start_addr = '0, cursor_addr = '0;
    logic [13:0] mem_addr;
    logic        cursor_on;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [13:0] m_addr = '0;
    logic [13:0] m_latch = '0;
    string m_src = "R4";

    always #2.5 clk = ~clk;

    disp_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .char_en(char_en), .frame_load(frame_load),
        .line_end(line_end), .row_last(row_last), .hdisp_hit(hdisp_hit),
        .cur_rows(cur_rows), .rowcol_mode(rowcol_mode), .start_addr(start_addr),
        .cursor_addr(cursor_addr), .mem_addr(mem_addr), .cursor_on(cursor_on)
    );

    // Plain-slot step: R3 binary, R9 column-only.
    function automatic logic [13:0] f_step(logic [13:0] a, logic rc);
        if (rc) return {a[13:8], a[7:0] + 8'd1};
        return a + 14'd1;
    endfunction

    // Capture value: R5 binary, R10 row/column.
    function automatic logic [13:0] f_capture(logic [13:0] a, logic [13:0] l, logic rc);
        if (rc) return {a[13:8] + 6'd1, l[7:0]};
        return a;
    endfunction

    task automatic check(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one slot at the falling edge, update the model after the rising
    // edge, and check both outputs at the next falling edge.
    task automatic slot(logic ce, logic fl, logic le, logic rl, logic hh,
                        logic cw, logic rc, logic [13:0] sa, logic [13:0] ca);
        string tag;
        logic  cap;
        char_en = ce; frame_load = fl; line_end = le; row_last = rl;
        hdisp_hit = hh; cur_rows = cw; rowcol_mode = rc;
        start_addr = sa; cursor_addr = ca;
        @(posedge clk);
        cap = rl && hh;
        if (!ce) tag = "R7";
        else if (fl) tag = (le || cap) ? "R6" : "R2";
        else if (le) tag = m_src;
        else tag = rc ? "R9" : "R3";
        if (ce) begin
            if (fl) begin
                m_addr = sa; m_latch = sa; m_src = "R2";
            end else begin
                logic [13:0] old_a;
                old_a = m_addr;
                m_addr = le ? m_latch : f_step(m_addr, rc);
                if (cap) begin
                    m_latch = f_capture(old_a, m_latch, rc);
                    m_src = rc ? "R10" : "R5";
                end
            end
        end
        @(negedge clk);
        check(tag, mem_addr, m_addr);
        check("R8", {13'd0, cursor_on}, {13'd0, cw && (mem_addr == ca)});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h5eed);
        // R1: reset clears the address and the row-start register.
        char_en = 1'b1; frame_load = 1'b1; start_addr = 14'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", mem_addr, 14'h0000);
        rst_n = 1'b1;
        slot(1, 0, 1, 0, 0, 0, 0, 14'h0, 14'h0);   // R1: line load shows a cleared register
        // R2/R3: frame load, then binary wrap 3FFE -> 3FFF -> 0000.
        slot(1, 1, 0, 0, 0, 0, 0, 14'h3ffe, 14'h0);
        slot(1, 0, 0, 0, 0, 1, 0, 14'h0, 14'h3fff);
        slot(1, 0, 0, 0, 0, 1, 0, 14'h0, 14'h0000);
        // R5: hdisp_hit alone does not capture; with row_last it does.
        slot(1, 0, 0, 0, 1, 0, 0, 14'h0, 14'h0);
        slot(1, 0, 1, 0, 0, 0, 0, 14'h0, 14'h0);   // R5: still 3FFE from the frame load
        slot(1, 0, 0, 1, 1, 0, 0, 14'h0, 14'h0);
        slot(1, 0, 1, 0, 0, 0, 0, 14'h0, 14'h0);
        // R7: a disabled slot ignores line_end, frame_load and capture.
        slot(0, 1, 1, 1, 1, 0, 0, 14'h2222, 14'h0);
        slot(0, 0, 1, 0, 0, 0, 0, 14'h0, 14'h0);
        // R6: frame load beats line end and capture.
        slot(1, 1, 1, 1, 1, 0, 0, 14'h0abc, 14'h0);
        slot(1, 0, 1, 0, 0, 0, 0, 14'h0, 14'h0);
        // R9/R10: column wrap 12FF -> 1200; row step with column kept.
        slot(1, 1, 0, 0, 0, 0, 1, 14'h12ff, 14'h0);
        slot(1, 0, 0, 0, 0, 0, 1, 14'h0, 14'h0);
        slot(1, 0, 0, 1, 1, 0, 1, 14'h0, 14'h0);
        slot(1, 0, 1, 0, 0, 0, 1, 14'h0, 14'h0);
        // R10: row field wraps 3F -> 00.
        slot(1, 1, 0, 0, 0, 0, 1, 14'h3f40, 14'h0);
        slot(1, 0, 0, 1, 1, 0, 1, 14'h0, 14'h0);
        slot(1, 0, 1, 0, 0, 0, 1, 14'h0, 14'h0);
        // Seeded random traffic over both modes.
        for (int seg = 0; seg < 8; seg++) begin
            logic rc;
            rc = $urandom % 2;
            for (int i = 0; i < 400; i++) begin
                logic [13:0] ca;
                ca = ($urandom % 2 == 0) ? f_step(m_addr, rc) : 14'($urandom);
                slot(($urandom % 8) != 0, ($urandom % 64) == 0,
                     ($urandom % 8) == 0, ($urandom % 4) == 0,
                     ($urandom % 6) == 0, $urandom % 2, rc,
                     14'($urandom), ca);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule